// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects interrupt requests from a parameterised number of external sources and delivers them to several processor contexts. A context is one privilege mode of one hardware thread. Every source has a programmable priority. Every context has its own enable bitmap over the sources and its own priority threshold, and it drives one registered interrupt line toward its processor.

Software works through a simple word-addressed register port. A context claims work by reading its claim register. The read returns the identifier of the best eligible source and takes that source out of the pending set. When the handler finishes, software writes the same identifier back to the same register. This completion re-arms the source. Sources can be wired as level-sensitive or as rising-edge-sensitive; a parameter mask selects the kind per source. Sources that are not connected are tied low and never become pending.

Top module: `plic_core`

## Requirements
- R1: Each context has one interrupt output. It is high exactly when at least one source is eligible for that context, and it is registered, so it follows any change of pending, enable, priority or threshold state one clock later.
- R2: A source whose enable bit is clear for a context never raises that context's output and is never returned by that context's claim. Enables are held independently per context.
- R3: Among eligible sources, a claim returns the one with the highest priority. When priorities are equal, the lowest source number wins.
- R4: A source is eligible only when its priority is strictly greater than the context's threshold. Priority 0 therefore never interrupts, and a threshold equal to a source's priority masks that source.
- R5: A claim read returns the winning source number, or 0 when nothing is eligible. In the same cycle it clears that source's pending bit, and the source cannot become pending again until it is completed.
- R6: Writing a source number to any context's claim/complete register completes that source. A level source whose input is still high becomes pending again one cycle after completion.
- R7: An edge source becomes pending on a rising edge of its input, and a steady high input does not pend it again. A rising edge that arrives while the source is claimed is held and becomes pending at completion.
- R8: The pending bitmap has bit s for source s. Writes to it are ignored. Sources whose input stays low never show as pending.
- R9: Reset (rst_n low, synchronous) clears all priorities, enables, thresholds, pending, claimed and held state, the interrupt outputs and the read data.
- R10: Register map (word addresses, 8 bits): priority of source s at s (s = 1..NSRC, low PRIO_W bits); pending bitmap at 0x20; enable bitmap of context c at 0x40+c (bit s = source s); threshold of context c at 0x60+2c; claim/complete of context c at 0x61+2c. Read data appears on reg_rdata the cycle after the reg_re cycle and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Source request lines; bit s is source s (1..NSRC) |
| reg_we | input | 1 | Register write strobe; takes precedence over reg_re |
| reg_re | input | 1 | Register read strobe; a read of a claim register claims |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | NCTX | Interrupt line per context |

## Verification
On every cycle the assertions check four things. An interrupt line is raised only when the previous cycle held an enabled pending source. A maximum threshold silences its context. A claim leaves the returned source non-pending and returns a number within range. A claimed source is never pending at the same time. The bench scenarios are the only way to show the rest: which source wins by priority and by lowest number, the strict threshold comparison, re-pending of a level source after completion, and the holding of an edge that arrives while its source is claimed.

// File: rtl/plic_pkg.sv
// Shared constants for the interrupt controller core: default sizes and the
// word addresses of the register groups. Assumes NSRC <= 31 so a bitmap fits
// in one data word, and NCTX <= 16 so context registers fit below 0x80.
package plic_pkg;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 32;
    localparam int NUM_SRC      = 7;
    localparam int NUM_CTX      = 2;
    localparam int PRIO_BITS    = 3;
    localparam logic [31:0] EDGE_DEFAULT = 32'h0000_00E0; // sources 5..7 edge
    localparam int PEND_ADDR    = 32'h20;
    localparam int EN_BASE      = 32'h40;
    localparam int CTX_BASE     = 32'h60;
endpackage

// File: rtl/plic_gate.sv
// Per-source gateway: turns a raw request line into a pending bit and keeps
// the claimed state until completion. EDGE selects rising-edge capture
// instead of level capture. Assumes claim and complete never coincide.
module plic_gate #(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic claim,
    input  logic complete,
    output logic pend_o,
    output logic busy_o
);
    logic prev_q, pend_q, busy_q, held_q;
    logic rise, req;

    assign rise = src & ~prev_q;

    // Choose the request condition for the source kind
    generate
        if (EDGE) begin : g_edge
            assign req = rise;
        end else begin : g_level
            assign req = src;
        end
    endgenerate

    // Track input history, pending, claimed and held-edge state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
            busy_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            prev_q <= src;
            if (claim) begin
                pend_q <= 1'b0;
                busy_q <= 1'b1;
            end else if (complete && busy_q) begin
                busy_q <= 1'b0;
                pend_q <= EDGE ? (held_q | rise) : 1'b0;
                held_q <= 1'b0;
            end else if (busy_q) begin
                if (EDGE && rise) held_q <= 1'b1;
            end else if (req) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign pend_o = pend_q;
    assign busy_o = busy_q;
endmodule

// File: rtl/plic_arb.sv
// Per-context arbiter: picks the eligible source with the highest priority,
// lowest number on ties. Eligible means pending, enabled and priority above
// the threshold. Purely combinational; bit 0 of pend is always zero.
module plic_arb #(
    parameter int NSRC   = 7,
    parameter int PRIO_W = 3,
    localparam int IDW   = $clog2(NSRC + 1)
) (
    input  logic [NSRC:0]             pend,
    input  logic [NSRC:0]             en,
    input  logic [NSRC:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thr,
    output logic [IDW-1:0]            best_id
);
    logic [PRIO_W-1:0] best_p;

    // Scan upward; strict compare keeps the lowest number among equals
    always_comb begin
        best_id = '0;
        best_p  = '0;
        for (int s = 0; s <= NSRC; s++) begin
            if (pend[s] && en[s] && (prio[s] > thr) && (prio[s] > best_p)) begin
                best_id = IDW'(s);
                best_p  = prio[s];
            end
        end
    end
endmodule

// File: rtl/plic_core.sv
// Interrupt controller top: register file, per-source gateways, per-context
// arbiters and registered interrupt lines. One register access per cycle;
// a write wins over a read when both strobes are high.
module plic_core
    import plic_pkg::*;
#(
    parameter int NSRC            = NUM_SRC,
    parameter int NCTX            = NUM_CTX,
    parameter int PRIO_W          = PRIO_BITS,
    parameter logic [31:0] EDGE_MASK = EDGE_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     src_i,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCTX-1:0]   irq_o
);
    localparam int IDW = $clog2(NSRC + 1);

    logic [NSRC:0][PRIO_W-1:0]            prio_q;
    logic [NCTX-1:0][NSRC:0]              en_q;
    logic [NCTX-1:0][PRIO_W-1:0]          thr_q;
    logic [NCTX-1:0]                      irq_q;
    logic [DATA_W-1:0]                    rdata_q, rd_val;
    logic [NSRC:1]                        pend_bits, busy_bits, claim_src, compl_src;
    logic [NSRC:0]                        pend_vec, busy_vec;
    logic [NCTX-1:0][IDW-1:0]             best_id;
    logic [NCTX-1:0]                      claim_hit, compl_hit;

    assign pend_vec = {pend_bits, 1'b0};
    assign busy_vec = {busy_bits, 1'b0};

    // One gateway per source, kind chosen from the edge mask
    for (genvar s = 1; s <= NSRC; s++) begin : g_src
        plic_gate #(.EDGE(EDGE_MASK[s])) u_gate (
            .clk(clk), .rst_n(rst_n), .src(src_i[s]),
            .claim(claim_src[s]), .complete(compl_src[s]),
            .pend_o(pend_bits[s]), .busy_o(busy_bits[s])
        );
    end

    // One arbiter per context
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        plic_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
            .pend(pend_vec), .en(en_q[c]), .prio(prio_q),
            .thr(thr_q[c]), .best_id(best_id[c])
        );
        assign claim_hit[c] = reg_re && !reg_we &&
                              (reg_addr == ADDR_W'(CTX_BASE + 2*c + 1));
        assign compl_hit[c] = reg_we && (reg_addr == ADDR_W'(CTX_BASE + 2*c + 1));
    end

    // Route claim and completion strobes to the addressed source
    always_comb begin
        claim_src = '0;
        compl_src = '0;
        for (int c = 0; c < NCTX; c++) begin
            for (int s = 1; s <= NSRC; s++) begin
                if (claim_hit[c] && best_id[c] == IDW'(s)) claim_src[s] = 1'b1;
                if (compl_hit[c] && reg_wdata == DATA_W'(s)) compl_src[s] = 1'b1;
            end
        end
    end

    // Select the read value for the current address
    always_comb begin
        rd_val = '0;
        for (int s = 1; s <= NSRC; s++)
            if (reg_addr == ADDR_W'(s)) rd_val[PRIO_W-1:0] = prio_q[s];
        if (reg_addr == ADDR_W'(PEND_ADDR)) rd_val[NSRC:0] = pend_vec;
        for (int c = 0; c < NCTX; c++) begin
            if (reg_addr == ADDR_W'(EN_BASE + c))        rd_val[NSRC:0]   = en_q[c];
            if (reg_addr == ADDR_W'(CTX_BASE + 2*c))     rd_val[PRIO_W-1:0] = thr_q[c];
            if (reg_addr == ADDR_W'(CTX_BASE + 2*c + 1)) rd_val[IDW-1:0]  = best_id[c];
        end
    end

    // Configuration registers, registered interrupt lines and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q  <= '0;
            en_q    <= '0;
            thr_q   <= '0;
            irq_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (reg_we) begin
                for (int s = 1; s <= NSRC; s++)
                    if (reg_addr == ADDR_W'(s)) prio_q[s] <= reg_wdata[PRIO_W-1:0];
                for (int c = 0; c < NCTX; c++) begin
                    if (reg_addr == ADDR_W'(EN_BASE + c))    en_q[c]  <= {reg_wdata[NSRC:1], 1'b0};
                    if (reg_addr == ADDR_W'(CTX_BASE + 2*c)) thr_q[c] <= reg_wdata[PRIO_W-1:0];
                end
            end else if (reg_re) begin
                rdata_q <= rd_val;
            end
            for (int c = 0; c < NCTX; c++) irq_q[c] <= (best_id[c] != '0);
        end
    end

    assign reg_rdata = rdata_q;
    assign irq_o     = irq_q;
endmodule

// File: rtl/plic_core_chk.sv
// Property checker for plic_core, bound into every instance. Observes the
// interrupt lines, pending and claimed state, enables, thresholds and claims.
module plic_core_chk #(
    parameter int NSRC   = 7,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NCTX-1:0]          irq_o,
    input logic [NSRC:0]            pend_vec,
    input logic [NSRC:0]            busy_vec,
    input logic [NCTX-1:0][NSRC:0]  en_q,
    input logic [NCTX-1:0][PRIO_W-1:0] thr_q,
    input logic                     claim_any,
    input logic [31:0]              rdata
);
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        // R1/R2: a raised line needs an enabled pending source one cycle before
        p_irq_has_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> $past(|(pend_vec & en_q[c])))
            else $error("irq without enabled pending source");
        // R4: maximum threshold masks every priority
        p_max_thr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_q[c] == '1) |=> !irq_o[c])
            else $error("irq above maximum threshold");
    end

    // R5: the returned source is no longer pending after a claim
    p_claim_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        claim_any |=> ((rdata == 32'd0) ||
                       (((pend_vec >> rdata) & {{NSRC{1'b0}}, 1'b1}) == '0)))
        else $error("claimed source still pending");
    // R5: a claim returns 0 or a valid source number
    p_claim_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        claim_any |=> (rdata <= 32'(NSRC)))
        else $error("claim out of range");
    // R6: a claimed source is never pending before completion
    p_busy_not_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_vec & pend_vec) == '0)
        else $error("claimed source pending");
endmodule

bind plic_core plic_core_chk #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .pend_vec(pend_vec),
    .busy_vec(busy_vec), .en_q(en_q), .thr_q(thr_q),
    .claim_any(|claim_hit), .rdata(reg_rdata)
);

// File: tb/plic_core_bench.sv
// Bench for plic_core: table of register operations and interrupt-line
// expectations, then directed edge-source and reset tests.
module plic_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:1]  src = 7'b0000111;   // sources 1..3 level, held high
    logic        we = 1'b0, re = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;
    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    plic_core u_plic_core (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_we(we), .reg_re(re),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
    );

    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_IQ = 2'd2;
    localparam int NV = 33;
    // {kind, address, data/expected, requirement}
    localparam logic [45:0] VEC [NV] = '{
        {K_RD, 8'h01, 32'h0,  4'd9},  // R9 priority reset
        {K_RD, 8'h40, 32'h0,  4'd9},  // R9 enable reset
        {K_RD, 8'h20, 32'h0E, 4'd8},  // R8 levels pend, source 4 idle
        {K_RD, 8'h61, 32'h0,  4'd4},  // R4 priority 0 never wins
        {K_WR, 8'h01, 32'd2,  4'd3},
        {K_WR, 8'h02, 32'd5,  4'd3},
        {K_WR, 8'h03, 32'd5,  4'd3},
        {K_IQ, 8'h00, 32'd0,  4'd2},  // R2 nothing enabled
        {K_WR, 8'h40, 32'h0E, 4'd2},
        {K_IQ, 8'h00, 32'd1,  4'd1},  // R1 context 0 raised
        {K_RD, 8'h02, 32'd5,  4'd10}, // R10 priority readback
        {K_RD, 8'h61, 32'd2,  4'd3},  // R3 tie -> lowest number
        {K_RD, 8'h20, 32'h0A, 4'd5},  // R5 claimed source cleared
        {K_RD, 8'h61, 32'd3,  4'd3},
        {K_RD, 8'h61, 32'd1,  4'd3},  // R3 lower priority last
        {K_RD, 8'h61, 32'd0,  4'd5},  // R5 empty claim
        {K_IQ, 8'h00, 32'd0,  4'd1},
        {K_WR, 8'h61, 32'd2,  4'd6},  // R6 complete source 2
        {K_IQ, 8'h00, 32'd1,  4'd6},
        {K_RD, 8'h20, 32'h04, 4'd6},  // R6 level re-pends
        {K_WR, 8'h60, 32'd5,  4'd4},
        {K_IQ, 8'h00, 32'd0,  4'd4},  // R4 equal to threshold masked
        {K_WR, 8'h60, 32'd4,  4'd4},
        {K_IQ, 8'h00, 32'd1,  4'd4},
        {K_WR, 8'h41, 32'h02, 4'd2},
        {K_IQ, 8'h00, 32'd1,  4'd2},  // R2 ctx1 quiet, source 1 claimed
        {K_WR, 8'h63, 32'd1,  4'd6},
        {K_IQ, 8'h00, 32'd3,  4'd6},  // R6 completion via other context
        {K_RD, 8'h63, 32'd1,  4'd5},
        {K_WR, 8'h20, 32'hFF, 4'd8},
        {K_RD, 8'h20, 32'h04, 4'd8},  // R8 write to pending ignored
        {K_RD, 8'h41, 32'h02, 4'd10},
        {K_RD, 8'h60, 32'd4,  4'd10}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int rq);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input int rq);
        @(negedge clk); re = 1'b1; addr = a;
        @(negedge clk); re = 1'b0;
        check(rdata, exp, rq);
    endtask

    task automatic chk_irq(input logic [1:0] exp, input int rq);
        @(negedge clk); @(negedge clk);
        check({30'd0, irq}, {30'd0, exp}, rq);
    endtask

    task automatic pulse5;
        @(negedge clk); src[5] = 1'b1;
        @(negedge clk); src[5] = 1'b0;
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1: watchdog expired, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({30'd0, irq}, 32'd0, 9);    // R9 outputs low in reset
        check(rdata, 32'd0, 9);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][45:44])
                K_WR: do_wr(VEC[i][43:36], VEC[i][35:4]);
                K_RD: do_rd(VEC[i][43:36], VEC[i][35:4], int'(VEC[i][3:0]));
                default: chk_irq(VEC[i][5:4], int'(VEC[i][3:0]));
            endcase
        end
        // R7 edge source 5: priority 7, threshold 6 hides source 2
        do_wr(8'h05, 32'd7);
        do_wr(8'h40, 32'h2E);
        do_wr(8'h60, 32'd6);
        chk_irq(2'b00, 7);
        pulse5();
        chk_irq(2'b01, 7);
        do_rd(8'h61, 32'd5, 7);
        pulse5();                          // R7 edge while claimed is held
        do_rd(8'h20, 32'h04, 7);
        do_wr(8'h61, 32'd5);
        do_rd(8'h20, 32'h24, 7);           // R7 held edge pends at completion
        do_rd(8'h61, 32'd5, 7);
        do_wr(8'h61, 32'd5);
        do_rd(8'h20, 32'h04, 7);
        @(negedge clk); src[5] = 1'b1;     // R7 steady high pends once
        repeat (2) @(negedge clk);
        do_rd(8'h61, 32'd5, 7);
        do_wr(8'h61, 32'd5);
        repeat (2) @(negedge clk);
        do_rd(8'h20, 32'h04, 7);
        src[5] = 1'b0;
        // R9 reset in mid-run clears configuration
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({30'd0, irq}, 32'd0, 9);
        do_rd(8'h02, 32'd0, 9);
        do_rd(8'h40, 32'd0, 9);
        do_rd(8'h60, 32'd0, 9);
        do_rd(8'h20, 32'h0E, 9);
        finish_run();
    end
endmodule